// File: doc/BRIEF.md
# SD Host Initialization Sequencer

This block is the host-side controller that brings a freshly powered SD-protocol storage device from power-up to the data transfer state. It does not drive the CMD line itself. Instead it asks an external command-line engine to send one command at a time, giving a 6-bit index and a 32-bit argument. That engine handles framing, CRC and response capture. It reports back with a response-valid strobe carrying the 32-bit response payload, or with a timeout flag.

After a start pulse the sequencer first asks for dummy clocks on an idle CMD line and waits until they are finished. It then issues the reset command and probes the interface condition. Next it runs the operating-condition loop, sending each application command behind the application prefix command. Once the card reports power-up complete, it collects the identification and the relative card address, selects the card and sets the data bus width.

While it works, the sequencer latches the relative card address and the capacity class. It ends either in done or in a held error code that tells the failures apart. A new start pulse runs the whole sequence again from the beginning.

Top module: `sd_init_seq`

## Requirements
- R1: After a start pulse, dclk_en is high and cmd_req stays low until dclk_done is seen. The first command after that is index 0 with argument 0. Index 0 completes on either rsp_valid or rsp_timeout.
- R2: After index 0 completes, index 8 is issued with argument 0x000001AA (supply code 0x1 in bits 11:8, check pattern 0xAA in bits 7:0).
- R3: Index 41 carries the voltage window 0x00FF8000, with bit 30 set to 1 if index 8 was answered and 0 if index 8 timed out.
- R4: If the index 8 response has bits 11:8 not equal to 0x1, the sequence fails with err_code 2. Otherwise, if bits 7:0 are not 0xAA, it fails with err_code 3. Voltage is checked first.
- R5: Every application command (index 41 and index 6) is preceded by index 55 with argument {rca,16'h0}, where rca is 0 before the address is assigned. A timeout on index 55 fails with err_code 1. cmd_req is high for exactly one cycle per command.
- R6: Index 41 is reissued, each time behind index 55, while response bit 31 is 0. After MAX_TRIES responses with bit 31 at 0 the sequence fails with err_code 4 and issues no further command.
- R7: high_cap becomes 1 only if index 8 was answered and the ready response to index 41 has bit 30 at 1. Otherwise it is 0.
- R8: Once the card is ready, index 2 (argument 0) and then index 3 (argument 0) are issued. The address is taken from bits 31:16 of the index 3 response. A zero address causes index 3 to be issued again.
- R9: Index 7 is issued with argument {rca,16'h0}, then index 55 and then index 6. The index 6 argument is 2 if wide_bus was 1 at start and 0 otherwise. The response to index 6 sets done to 1 with err_code 0.
- R10: A timeout on any command other than index 0 and index 8 fails with err_code 1. done stays 0 and no further command is issued.
- R11: A start pulse while a sequence is in progress is ignored and the sequence continues with the next command.
- R12: After reset, cmd_req, dclk_en, done, high_cap, rca and err_code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when not busy |
| wide_bus | input | 1 | Select a 4-line data bus (captured at start) |
| dclk_done | input | 1 | Dummy clock burst has finished |
| dclk_en | output | 1 | Request dummy clocks with CMD held high |
| cmd_req | output | 1 | One-cycle request to send a command |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response received strobe |
| rsp_data | input | 32 | Response payload |
| rsp_timeout | input | 1 | No response strobe |
| rca | output | 16 | Captured relative card address |
| high_cap | output | 1 | High-capacity card |
| done | output | 1 | Card is in the data transfer state |
| err_code | output | 3 | 0 none, 1 timeout, 2 voltage, 3 pattern, 4 retries exhausted |

## Verification
The assertions take for granted that the command engine answers only while a command is outstanding. They also assume it never raises rsp_valid and rsp_timeout in the same cycle, and that dclk_done arrives only while dummy clocks are requested. The bench follows these rules by acting as that engine. It waits for each one-cycle request and checks the index and argument. One cycle later it returns exactly one strobe, held for a single cycle. The bench pulses start only while the block is waiting on a response or is idle.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DCLK,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef enum logic [3:0] {
        SP_GO_IDLE,
        SP_IF_COND,
        SP_APP_OP,
        SP_OP_COND,
        SP_ALL_CID,
        SP_REL_ADDR,
        SP_SELECT,
        SP_APP_BUS,
        SP_BUS_WIDTH
    } seq_step_e;

    typedef enum logic [2:0] {
        ER_NONE    = 3'd0,
        ER_TIMEOUT = 3'd1,
        ER_VOLT    = 3'd2,
        ER_PATTERN = 3'd3,
        ER_RETRY   = 3'd4
    } init_err_e;

    localparam logic [3:0]  HOST_VHS     = 4'h1;
    localparam logic [7:0]  ECHO_PATTERN = 8'hAA;
    localparam logic [23:0] VDD_WINDOW   = 24'hFF8000;
    localparam logic [1:0]  BUS_CODE_4   = 2'b10;
    localparam logic [1:0]  BUS_CODE_1   = 2'b00;

    typedef struct packed {
        logic        volt_ok;
        logic        echo_ok;
        logic        powered;
        logic        ccs;
        logic [15:0] new_rca;
    } rsp_fields_t;

    function automatic logic [5:0] step_cmd(seq_step_e s);
        case (s)
            SP_GO_IDLE:   return 6'd0;
            SP_IF_COND:   return 6'd8;
            SP_APP_OP:    return 6'd55;
            SP_OP_COND:   return 6'd41;
            SP_ALL_CID:   return 6'd2;
            SP_REL_ADDR:  return 6'd3;
            SP_SELECT:    return 6'd7;
            SP_APP_BUS:   return 6'd55;
            SP_BUS_WIDTH: return 6'd6;
            default:      return 6'd0;
        endcase
    endfunction

    function automatic logic [31:0] step_arg(seq_step_e s, logic [15:0] addr,
                                             logic hcs, logic wide);
        case (s)
            SP_IF_COND:   return {20'h0, HOST_VHS, ECHO_PATTERN};
            SP_APP_OP,
            SP_SELECT,
            SP_APP_BUS:   return {addr, 16'h0};
            SP_OP_COND:   return {1'b0, hcs, 6'b0, VDD_WINDOW};
            SP_BUS_WIDTH: return {30'h0, wide ? BUS_CODE_4 : BUS_CODE_1};
            default:      return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sd_rsp_fields.sv
module sd_rsp_fields
    import sd_init_pkg::*;
(
    input  logic [31:0] rsp_data,
    output rsp_fields_t fields
);
    logic unused_bits;
    assign unused_bits = ^rsp_data[15:12];

    always_comb begin
        fields.volt_ok = (rsp_data[11:8] == HOST_VHS);
        fields.echo_ok = (rsp_data[7:0] == ECHO_PATTERN);
        fields.powered = rsp_data[31];
        fields.ccs     = rsp_data[30];
        fields.new_rca = rsp_data[31:16];
    end
endmodule

// File: rtl/sd_try_counter.sv
module sd_try_counter #(
    parameter int MAX_TRIES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_TRIES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && !last)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_VAL);

    // R6
    try_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_VAL);

    // R6
    try_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (last && !clr) |=> last);
endmodule

// File: rtl/sd_init_fsm.sv
module sd_init_fsm
    import sd_init_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        wide_bus,
    input  logic        dclk_done,
    input  logic        rsp_valid,
    input  logic        rsp_timeout,
    input  rsp_fields_t fields,
    input  logic        try_last,
    output logic        try_clr,
    output logic        try_inc,
    output logic        dclk_en,
    output logic        cmd_req,
    output logic [5:0]  cmd_idx,
    output logic [31:0] cmd_arg,
    output logic [15:0] rca,
    output logic        high_cap,
    output logic        done,
    output logic [2:0]  err_code
);
    seq_state_e  state;
    seq_step_e   step;
    init_err_e   err_q;
    logic [15:0] rca_q;
    logic        v2_q;
    logic        hc_q;
    logic        wide_q;
    logic        can_start;

    assign can_start = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
    assign try_clr   = can_start && start;
    assign try_inc   = (state == ST_WAIT) && rsp_valid && (step == SP_OP_COND)
                       && !fields.powered;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            step   <= SP_GO_IDLE;
            err_q  <= ER_NONE;
            rca_q  <= 16'h0;
            v2_q   <= 1'b0;
            hc_q   <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        state  <= ST_DCLK;
                        step   <= SP_GO_IDLE;
                        err_q  <= ER_NONE;
                        rca_q  <= 16'h0;
                        v2_q   <= 1'b0;
                        hc_q   <= 1'b0;
                        wide_q <= wide_bus;
                    end
                end
                ST_DCLK: begin
                    if (dclk_done)
                        state <= ST_ISSUE;
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp_valid) begin
                        state <= ST_ISSUE;
                        case (step)
                            SP_GO_IDLE: step <= SP_IF_COND;
                            SP_IF_COND: begin
                                if (!fields.volt_ok) begin
                                    state <= ST_FAIL;
                                    err_q <= ER_VOLT;
                                end else if (!fields.echo_ok) begin
                                    state <= ST_FAIL;
                                    err_q <= ER_PATTERN;
                                end else begin
                                    v2_q <= 1'b1;
                                    step <= SP_APP_OP;
                                end
                            end
                            SP_APP_OP: step <= SP_OP_COND;
                            SP_OP_COND: begin
                                if (fields.powered) begin
                                    hc_q <= v2_q && fields.ccs;
                                    step <= SP_ALL_CID;
                                end else if (try_last) begin
                                    state <= ST_FAIL;
                                    err_q <= ER_RETRY;
                                end else begin
                                    step <= SP_APP_OP;
                                end
                            end
                            SP_ALL_CID: step <= SP_REL_ADDR;
                            SP_REL_ADDR: begin
                                if (fields.new_rca != 16'h0) begin
                                    rca_q <= fields.new_rca;
                                    step  <= SP_SELECT;
                                end
                            end
                            SP_SELECT:  step <= SP_APP_BUS;
                            SP_APP_BUS: step <= SP_BUS_WIDTH;
                            SP_BUS_WIDTH: state <= ST_DONE;
                            default: begin
                                state <= ST_FAIL;
                                err_q <= ER_TIMEOUT;
                            end
                        endcase
                    end else if (rsp_timeout) begin
                        if (step == SP_GO_IDLE) begin
                            state <= ST_ISSUE;
                            step  <= SP_IF_COND;
                        end else if (step == SP_IF_COND) begin
                            state <= ST_ISSUE;
                            step  <= SP_APP_OP;
                        end else begin
                            state <= ST_FAIL;
                            err_q <= ER_TIMEOUT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign dclk_en  = (state == ST_DCLK);
    assign cmd_req  = (state == ST_ISSUE);
    assign done     = (state == ST_DONE);
    assign cmd_idx  = step_cmd(step);
    assign cmd_arg  = step_arg(step, rca_q, v2_q, wide_q);
    assign rca      = rca_q;
    assign high_cap = hc_q;
    assign err_code = err_q;

    // R1
    dclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DCLK && !dclk_done) |=> !cmd_req);

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_req |=> !cmd_req);

    // R8
    select_rca_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && step == SP_SELECT) |-> (rca_q != 16'h0));

    // R9
    done_clean_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (err_q == ER_NONE && rca_q != 16'h0));

    // R7
    hc_v2_chk: assert property (@(posedge clk) disable iff (rst)
        hc_q |-> v2_q);

    // R10
    fail_code_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAIL) |-> (err_q != ER_NONE));
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
    import sd_init_pkg::*;
#(
    parameter int MAX_TRIES = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        wide_bus,
    input  logic        dclk_done,
    output logic        dclk_en,
    output logic        cmd_req,
    output logic [5:0]  cmd_idx,
    output logic [31:0] cmd_arg,
    input  logic        rsp_valid,
    input  logic [31:0] rsp_data,
    input  logic        rsp_timeout,
    output logic [15:0] rca,
    output logic        high_cap,
    output logic        done,
    output logic [2:0]  err_code
);
    rsp_fields_t fields;
    logic        try_clr;
    logic        try_inc;
    logic        try_last;

    sd_rsp_fields u_fields (
        .rsp_data (rsp_data),
        .fields   (fields)
    );

    sd_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk  (clk),
        .rst  (rst),
        .clr  (try_clr),
        .inc  (try_inc),
        .last (try_last)
    );

    sd_init_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .wide_bus    (wide_bus),
        .dclk_done   (dclk_done),
        .rsp_valid   (rsp_valid),
        .rsp_timeout (rsp_timeout),
        .fields      (fields),
        .try_last    (try_last),
        .try_clr     (try_clr),
        .try_inc     (try_inc),
        .dclk_en     (dclk_en),
        .cmd_req     (cmd_req),
        .cmd_idx     (cmd_idx),
        .cmd_arg     (cmd_arg),
        .rca         (rca),
        .high_cap    (high_cap),
        .done        (done),
        .err_code    (err_code)
    );
endmodule

// File: tb/sd_init_seq_tb.sv
`timescale 1ns/1ps
module sd_init_seq_tb;
    localparam int BENCH_TRIES = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wide_bus = 1'b0;
    logic        dclk_done = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = 32'h0;
    logic        rsp_timeout = 1'b0;
    logic        dclk_en, cmd_req, high_cap, done;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic [15:0] rca;
    logic [2:0]  err_code;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    sd_init_seq #(.MAX_TRIES(BENCH_TRIES)) u_dut (
        .clk(clk), .rst(rst), .start(start), .wide_bus(wide_bus),
        .dclk_done(dclk_done), .dclk_en(dclk_en), .cmd_req(cmd_req),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_timeout(rsp_timeout), .rca(rca),
        .high_cap(high_cap), .done(done), .err_code(err_code)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_cmd(input logic [5:0] idx, input logic [31:0] arg,
                              input string tag);
        int w = 0;
        while (!cmd_req && w < 40) begin
            @(negedge clk);
            w++;
        end
        check(cmd_req == 1'b1, {tag, " request"}, 32'(cmd_req), 32'd1);
        check(cmd_idx == idx, {tag, " index"}, 32'(cmd_idx), 32'(idx));
        check(cmd_arg == arg, {tag, " argument"}, cmd_arg, arg);
        @(negedge clk);
    endtask

    task automatic reply(input logic [31:0] data);
        rsp_data  = data;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic reply_to();
        rsp_timeout = 1'b1;
        @(negedge clk);
        rsp_timeout = 1'b0;
    endtask

    task automatic check_end(input logic [2:0] err, input logic dn, input string tag);
        check(err_code == err, {tag, " err_code"}, 32'(err_code), 32'(err));
        check(done == dn, {tag, " done"}, 32'(done), 32'(dn));
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(cmd_req == 1'b0, {tag, " no further command"}, 32'(cmd_req), 32'd0);
        end
    endtask

    // start, dummy clocks, index 0 and index 8 (R1, R2)
    task automatic to_cmd8(input logic wide, input logic cmd0_to);
        wide_bus = wide;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(dclk_en == 1'b1, "R1 dclk_en during dummy clocks", 32'(dclk_en), 32'd1);
            check(cmd_req == 1'b0, "R1 no command before dclk_done", 32'(cmd_req), 32'd0);
            @(negedge clk);
        end
        dclk_done = 1'b1;
        @(negedge clk);
        dclk_done = 1'b0;
        expect_cmd(6'd0, 32'h0, "R1 reset command");
        if (cmd0_to) reply_to(); else reply(32'h0);
        expect_cmd(6'd8, 32'h000001AA, "R2 interface probe");
    endtask

    task automatic op_round(input logic [31:0] addr_arg, input logic [31:0] a41,
                            input logic [31:0] ocr);
        expect_cmd(6'd55, addr_arg, "R5 prefix before op cond");
        reply(32'h0);
        expect_cmd(6'd41, a41, "R3 op cond");
        reply(ocr);
    endtask

    task automatic t_reset();
        check(cmd_req == 1'b0, "R12 reset cmd_req", 32'(cmd_req), 32'd0);
        check(dclk_en == 1'b0, "R12 reset dclk_en", 32'(dclk_en), 32'd0);
        check(high_cap == 1'b0, "R12 reset high_cap", 32'(high_cap), 32'd0);
        check(rca == 16'h0, "R12 reset rca", 32'(rca), 32'd0);
        check_end(3'd0, 1'b0, "R12 reset");
    endtask

    task automatic t_v2_high();
        to_cmd8(1'b1, 1'b0);
        reply(32'h000001AA);
        op_round(32'h0, 32'h40FF8000, 32'h00FF8000);
        op_round(32'h0, 32'h40FF8000, 32'h00FF8000);
        op_round(32'h0, 32'h40FF8000, 32'hC0FF8000);
        check(high_cap == 1'b1, "R7 high capacity after ready", 32'(high_cap), 32'd1);
        expect_cmd(6'd2, 32'h0, "R8 identification");
        reply(32'h0);
        expect_cmd(6'd3, 32'h0, "R8 address request");
        reply(32'h0000_0000);
        expect_cmd(6'd3, 32'h0, "R8 reissue on zero address");
        reply(32'h1234_0000);
        check(rca == 16'h1234, "R8 captured address", 32'(rca), 32'h1234);
        expect_cmd(6'd7, 32'h1234_0000, "R9 select");
        reply(32'h0);
        expect_cmd(6'd55, 32'h1234_0000, "R5 prefix with address");
        reply(32'h0);
        expect_cmd(6'd6, 32'h2, "R9 bus width 4");
        check(done == 1'b0, "R9 not done before last response", 32'(done), 32'd0);
        reply(32'h0);
        check_end(3'd0, 1'b1, "R9 finished");
        check(high_cap == 1'b1, "R7 high capacity kept", 32'(high_cap), 32'd1);
    endtask

    task automatic t_v1();
        to_cmd8(1'b0, 1'b1);
        reply_to();
        op_round(32'h0, 32'h00FF8000, 32'hC0FF8000);
        check(high_cap == 1'b0, "R7 legacy card ignores capacity bit", 32'(high_cap), 32'd0);
        expect_cmd(6'd2, 32'h0, "R8 identification");
        reply(32'h0);
        expect_cmd(6'd3, 32'h0, "R8 address request");
        reply(32'hBEEF_0000);
        expect_cmd(6'd7, 32'hBEEF_0000, "R9 select");
        reply(32'h0);
        expect_cmd(6'd55, 32'hBEEF_0000, "R5 prefix with address");
        reply(32'h0);
        expect_cmd(6'd6, 32'h0, "R9 bus width 1");
        reply(32'h0);
        check_end(3'd0, 1'b1, "R9 legacy finished");
        check(rca == 16'hBEEF, "R8 legacy address", 32'(rca), 32'hBEEF);
    endtask

    task automatic t_volt();
        to_cmd8(1'b0, 1'b0);
        reply(32'h0000_02AA);
        check_end(3'd2, 1'b0, "R4 voltage mismatch");
        quiet(3, "R4 voltage mismatch");
        to_cmd8(1'b0, 1'b0);
        reply(32'h0000_0255);
        check_end(3'd2, 1'b0, "R4 voltage before pattern");
    endtask

    task automatic t_pattern();
        to_cmd8(1'b0, 1'b0);
        reply(32'h0000_01AB);
        check_end(3'd3, 1'b0, "R4 pattern mismatch");
        quiet(3, "R4 pattern mismatch");
    endtask

    task automatic t_retry();
        to_cmd8(1'b0, 1'b0);
        reply(32'h000001AA);
        for (int i = 0; i < BENCH_TRIES; i++) begin
            if (i > 0)
                check(err_code == 3'd0, "R6 still retrying", 32'(err_code), 32'd0);
            op_round(32'h0, 32'h40FF8000, 32'h40FF8000);
        end
        check_end(3'd4, 1'b0, "R6 retries exhausted");
        quiet(4, "R6 retries exhausted");
    endtask

    task automatic t_std_timeout();
        to_cmd8(1'b0, 1'b0);
        reply(32'h000001AA);
        op_round(32'h0, 32'h40FF8000, 32'h80FF8000);
        check(high_cap == 1'b0, "R7 standard capacity", 32'(high_cap), 32'd0);
        expect_cmd(6'd2, 32'h0, "R10 identification");
        reply_to();
        check_end(3'd1, 1'b0, "R10 identification timeout");
        quiet(3, "R10 timeout");
    endtask

    task automatic t_prefix_timeout();
        to_cmd8(1'b0, 1'b0);
        reply(32'h000001AA);
        expect_cmd(6'd55, 32'h0, "R5 prefix");
        reply_to();
        check_end(3'd1, 1'b0, "R5 prefix timeout");
    endtask

    task automatic t_start_busy();
        to_cmd8(1'b0, 1'b0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(dclk_en == 1'b0, "R11 start ignored while busy", 32'(dclk_en), 32'd0);
        reply(32'h000001AA);
        expect_cmd(6'd55, 32'h0, "R11 sequence continues");
        reply(32'h0);
        expect_cmd(6'd41, 32'h40FF8000, "R11 sequence continues");
        reply_to();
        check_end(3'd1, 1'b0, "R10 op cond timeout");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_v2_high();
        t_v1();
        t_volt();
        t_pattern();
        t_retry();
        t_std_timeout();
        t_prefix_timeout();
        t_start_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule